// File: doc/BRIEF.md
# GPIO Level-Hold Interrupt Controller

This block produces interrupt requests for one 8-bit GPIO port. It watches the pad values and counts how long each one stays at its active level. A pin raises a request only after it has stayed active for longer than a programmable qualification time, which filters out short glitches and contact bounce. A pin that is not enabled, or that drops back to its inactive level before the time has elapsed, raises nothing.

Software reaches the block through a byte-wide register bus with one write strobe. It selects the active level of each pin, the pins that may interrupt, a hold time from a table of eight values between 2 ms and 100 ms, and a 4-bit routing code. The routing code is passed on to the system interrupt controller. Each pin can fire once per activation, or it can fire again after every further hold period while its level persists. Requests collect in a pending register that software clears by writing 1 to a bit. The single interrupt line is the OR of the pending bits, gated by the global enable and by a non-zero routing code.

A free-running prescaler makes a 1 ms tick every `TICK_DIV` clocks. A smaller `TICK_DIV` gives short periods in simulation.

Top module: `holdIrq`

## Requirements
- R1: After reset the registers read mask=00h, level=FFh, control=00h, mode=00h and pending=00h, and `irqOut` and `routeCode` are 0. The register addresses are 0 for mask, 1 for level, 2 for control, 3 for mode and 4 for pending. Addresses 5 to 7 read as 0.
- R2: Pin i counts and can set pending bit i only while bit i of the mask register is 1. A pin whose mask bit is 0 never sets its pending bit.
- R3: Level bit i set to 1 makes pin i active when its pad is low. Level bit i set to 0 makes pin i active when its pad is high. A pin at its inactive level never sets pending.
- R4: Control bit 7 is the global enable. While it is 0, no pin counts and `irqOut` stays low.
- R5: Control bits 6:4 select the hold time N in ms: 0→2, 1→5, 2→10, 3→20, 4→40, 5→60, 6→80, 7→100. One ms is TICK_DIV clocks, and a tick occurs on each rising edge whose count since reset release is a multiple of TICK_DIV. If a pin becomes active before edge m+1 and stays active, its pending bit is set on edge T1+N·TICK_DIV, where T1 is the first tick edge at or after edge m+1. If the pin leaves its active level before that edge, nothing is set and the count restarts from zero.
- R6: Mode bit i set to 0 (once) sets pending bit i a single time per activation. The pin re-arms only after its level has gone inactive.
- R7: Mode bit i set to 1 (continuous) sets pending bit i again every N·TICK_DIV clocks while the level stays active.
- R8: `routeCode` equals control bits 3:0. `irqOut` is high when the global enable is set, the routing code is non-zero and any pending bit is set. With routing code 0, pending bits are still recorded but `irqOut` stays low.
- R9: A write to pending (address 4) clears each bit written as 1 and leaves the bits written as 0 unchanged. A new request in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| padIn | input | 8 | Pad values of the port, synchronous to clk |
| regWr | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | 3 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Read data for regAddr (combinational) |
| irqOut | output | 1 | Interrupt request line |
| routeCode | output | 4 | Routing code for the system interrupt controller |

## Verification
The assertions assume that `padIn` is already synchronous to `clk`, because the block has no synchronizer of its own. They also assume that each write is a single-cycle strobe and that `TICK_DIV` is at least 2, so that two ticks never fall on adjacent edges. The bench changes pads and bus signals only on falling edges and runs with `TICK_DIV`=2. This lets it predict every firing edge from the cycle count since reset, and every stimulus stays inside these assumptions.

// File: rtl/holdIrqPkg.sv
`timescale 1ns/1ps
package holdIrqPkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int HOLD_W = 7;   // holds up to 100 ms
  localparam int ROUTE_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_MASK  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_LEVEL = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_MODE  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_PEND  = 3'd4;

  localparam int CTRL_EN_BIT  = 7;
  localparam int CTRL_PER_LSB = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic              tick;
    logic              countEn;
    logic [HOLD_W-1:0] limit;
    logic [DATA_W-1:0] clrMask;
  } ctrlStrobe_t;

  // Hold period code to milliseconds
  function automatic logic [HOLD_W-1:0] periodMs(input logic [2:0] code);
    case (code)
      3'd0:    periodMs = 7'd2;
      3'd1:    periodMs = 7'd5;
      3'd2:    periodMs = 7'd10;
      3'd3:    periodMs = 7'd20;
      3'd4:    periodMs = 7'd40;
      3'd5:    periodMs = 7'd60;
      3'd6:    periodMs = 7'd80;
      default: periodMs = 7'd100;
    endcase
  endfunction
endpackage

// File: rtl/holdIrqCtrl.sv
`timescale 1ns/1ps
module holdIrqCtrl
  import holdIrqPkg::*;
#(
  parameter int PIN_COUNT = 8,
  parameter int TICK_DIV  = 14318
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 regWr,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWdata,
  input  logic [PIN_COUNT-1:0] pendingQ,
  output logic [DATA_W-1:0]    regRdata,
  output logic [PIN_COUNT-1:0] maskQ,
  output logic [PIN_COUNT-1:0] levelQ,
  output logic [PIN_COUNT-1:0] modeQ,
  output logic [ROUTE_W-1:0]   routeCode,
  output logic                 globalEn,
  output ctrlStrobe_t          strobes
);
  localparam int DIV_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  logic [DATA_W-1:0] ctrlQ;
  logic [DIV_W-1:0]  divCnt;
  logic wrMask, wrLevel, wrCtrl, wrMode, wrPend;

  assign wrMask  = regWr && (regAddr == ADDR_MASK);
  assign wrLevel = regWr && (regAddr == ADDR_LEVEL);
  assign wrCtrl  = regWr && (regAddr == ADDR_CTRL);
  assign wrMode  = regWr && (regAddr == ADDR_MODE);
  assign wrPend  = regWr && (regAddr == ADDR_PEND);

  // Configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      maskQ  <= '0;
      levelQ <= '1;
      ctrlQ  <= '0;
      modeQ  <= '0;
    end else begin
      if (wrMask)  maskQ  <= regWdata[PIN_COUNT-1:0];
      if (wrLevel) levelQ <= regWdata[PIN_COUNT-1:0];
      if (wrCtrl)  ctrlQ  <= regWdata;
      if (wrMode)  modeQ  <= regWdata[PIN_COUNT-1:0];
    end
  end

  // Millisecond prescaler
  always_ff @(posedge clk) begin
    if (rst)                    divCnt <= '0;
    else if (divCnt == DIV_LAST) divCnt <= '0;
    else                        divCnt <= divCnt + DIV_W'(1);
  end

  assign globalEn  = ctrlQ[CTRL_EN_BIT];
  assign routeCode = ctrlQ[ROUTE_W-1:0];

  always_comb begin
    strobes.tick    = (divCnt == DIV_LAST);
    strobes.countEn = globalEn;
    strobes.limit   = periodMs(ctrlQ[CTRL_PER_LSB +: 3]);
    strobes.clrMask = wrPend ? regWdata : '0;
  end

  // Read mux
  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_MASK:  regRdata[PIN_COUNT-1:0] = maskQ;
      ADDR_LEVEL: regRdata[PIN_COUNT-1:0] = levelQ;
      ADDR_CTRL:  regRdata = ctrlQ;
      ADDR_MODE:  regRdata[PIN_COUNT-1:0] = modeQ;
      ADDR_PEND:  regRdata[PIN_COUNT-1:0] = pendingQ;
      default:    regRdata = '0;
    endcase
  end
endmodule

// File: rtl/holdIrqDatapath.sv
`timescale 1ns/1ps
module holdIrqDatapath
  import holdIrqPkg::*;
#(
  parameter int PIN_COUNT = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PIN_COUNT-1:0] padIn,
  input  logic [PIN_COUNT-1:0] maskQ,
  input  logic [PIN_COUNT-1:0] levelQ,
  input  logic [PIN_COUNT-1:0] modeQ,
  input  ctrlStrobe_t          strobes,
  output logic [PIN_COUNT-1:0] pendingQ
);
  logic [PIN_COUNT-1:0] fire;

  for (genvar g = 0; g < PIN_COUNT; g++) begin : gPin
    logic [HOLD_W-1:0] holdCnt;
    logic armed;
    logic qual;
    logic reached;

    assign qual    = strobes.countEn & maskQ[g] & (padIn[g] ^ levelQ[g]);
    // >= so that lowering the period mid-count still fires
    assign reached = (holdCnt >= strobes.limit);
    assign fire[g] = qual & strobes.tick & armed & reached;

    always_ff @(posedge clk) begin
      if (rst || !qual) begin
        holdCnt <= '0;
        armed   <= 1'b1;
      end else if (strobes.tick && armed) begin
        if (reached) begin
          if (modeQ[g]) begin
            holdCnt <= HOLD_W'(1);  // next period starts at this tick
          end else begin
            holdCnt <= '0;
            armed   <= 1'b0;
          end
        end else begin
          holdCnt <= holdCnt + HOLD_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pendingQ <= '0;
    else     pendingQ <= fire | (pendingQ & ~strobes.clrMask[PIN_COUNT-1:0]);
  end
endmodule

// File: rtl/holdIrq.sv
`timescale 1ns/1ps
module holdIrq
  import holdIrqPkg::*;
#(
  parameter int PIN_COUNT = 8,
  parameter int TICK_DIV  = 14318
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PIN_COUNT-1:0] padIn,
  input  logic                 regWr,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWdata,
  output logic [DATA_W-1:0]    regRdata,
  output logic                 irqOut,
  output logic [ROUTE_W-1:0]   routeCode
);
  ctrlStrobe_t          strobes;
  logic [PIN_COUNT-1:0] maskQ, levelQ, modeQ, pendingQ;
  logic                 globalEn;

  holdIrqCtrl #(.PIN_COUNT(PIN_COUNT), .TICK_DIV(TICK_DIV)) ctrl (
    .clk(clk), .rst(rst), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .pendingQ(pendingQ), .regRdata(regRdata), .maskQ(maskQ), .levelQ(levelQ),
    .modeQ(modeQ), .routeCode(routeCode), .globalEn(globalEn), .strobes(strobes)
  );

  holdIrqDatapath #(.PIN_COUNT(PIN_COUNT)) dp (
    .clk(clk), .rst(rst), .padIn(padIn), .maskQ(maskQ), .levelQ(levelQ),
    .modeQ(modeQ), .strobes(strobes), .pendingQ(pendingQ)
  );

  assign irqOut = globalEn & (|routeCode) & (|pendingQ);
endmodule

// File: rtl/holdIrqChecker.sv
`timescale 1ns/1ps
module holdIrqChecker
  import holdIrqPkg::*;
#(
  parameter int PIN_COUNT = 8,
  parameter int TICK_DIV  = 14318
) (
  input logic                 clk,
  input logic                 rst,
  input logic [PIN_COUNT-1:0] padIn,
  input logic                 regWr,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [DATA_W-1:0]    regWdata,
  input logic [PIN_COUNT-1:0] maskQ,
  input logic [PIN_COUNT-1:0] levelQ,
  input logic                 globalEn,
  input logic                 tick,
  input logic [PIN_COUNT-1:0] pendingQ
);
  for (genvar g = 0; g < PIN_COUNT; g++) begin : gChk
    assert_pend_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(pendingQ[g]) |-> $past(tick));
    assert_pend_masked_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(pendingQ[g]) |-> $past(maskQ[g]));
    assert_pend_level_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(pendingQ[g]) |-> $past(padIn[g] ^ levelQ[g]));
    assert_pend_enabled_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(pendingQ[g]) |-> $past(globalEn));
    assert_pend_w1c_R9: assert property (@(posedge clk) disable iff (rst)
      $fell(pendingQ[g]) |-> $past(regWr && (regAddr == ADDR_PEND) && regWdata[g]));
  end

  if (TICK_DIV > 1) begin : gTick
    assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick);
  end
endmodule

bind holdIrq holdIrqChecker #(.PIN_COUNT(PIN_COUNT), .TICK_DIV(TICK_DIV)) chk (
  .clk(clk), .rst(rst), .padIn(padIn), .regWr(regWr), .regAddr(regAddr),
  .regWdata(regWdata), .maskQ(maskQ), .levelQ(levelQ), .globalEn(globalEn),
  .tick(strobes.tick), .pendingQ(pendingQ)
);

// File: tb/holdIrq_test.sv
`timescale 1ns/1ps
module holdIrq_test;
  import holdIrqPkg::*;
  localparam int DIV = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] padIn = '0;
  logic regWr = 1'b0;
  logic [2:0] regAddr = ADDR_PEND;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic irqOut;
  logic [3:0] routeCode;

  int compared = 0;
  int mismatched = 0;
  int edgeCount = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (rst) edgeCount <= 0;
    else     edgeCount <= edgeCount + 1;
  end

  holdIrq #(.PIN_COUNT(8), .TICK_DIV(DIV)) uut (
    .clk(clk), .rst(rst), .padIn(padIn), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut), .routeCode(routeCode)
  );

  function automatic int msOf(input int code);
    int t[8] = '{2, 5, 10, 20, 40, 60, 80, 100};
    return t[code];
  endfunction

  function automatic int fireEdge(input int m, input int lim);
    return ((m / DIV) + 1) * DIV + lim * DIV;
  endfunction

  task automatic checkVal(input string req, input int actual, input int expected);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regAddr = ADDR_PEND;
  endtask

  task automatic readReg(input logic [2:0] a, output int d);
    @(negedge clk);
    regAddr = a;
    #1 d = int'(regRdata);
    regAddr = ADDR_PEND;
  endtask

  task automatic activate(input int pin, input bit activeLow, output int m);
    @(negedge clk);
    padIn[pin] = activeLow ? 1'b0 : 1'b1;
    m = edgeCount;
  endtask

  task automatic measure(input int pin, input int maxCycles, output int seen);
    seen = -1;
    regAddr = ADDR_PEND;
    for (int k = 0; k < maxCycles; k++) begin
      @(negedge clk);
      if (regRdata[pin]) begin
        seen = edgeCount;
        break;
      end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic teardown();
    writeReg(ADDR_CTRL, 8'h00);
    padIn = '0;
    writeReg(ADDR_LEVEL, 8'h00);
    writeReg(ADDR_MASK, 8'h00);
    writeReg(ADDR_MODE, 8'h00);
    writeReg(ADDR_PEND, 8'hFF);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog (all requirements): actual hung expected done");
    finish();
  end

  initial begin
    int d, m, m2, got, f1, f2, lim;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    readReg(ADDR_MASK, d);  checkVal("R1 mask reset", d, 8'h00);
    readReg(ADDR_LEVEL, d); checkVal("R1 level reset", d, 8'hFF);
    readReg(ADDR_CTRL, d);  checkVal("R1 ctrl reset", d, 8'h00);
    readReg(ADDR_MODE, d);  checkVal("R1 mode reset", d, 8'h00);
    readReg(ADDR_PEND, d);  checkVal("R1 pending reset", d, 8'h00);
    readReg(3'd6, d);       checkVal("R1 unused address", d, 0);
    checkVal("R1 irqOut reset", int'(irqOut), 0);
    checkVal("R1 routeCode reset", int'(routeCode), 0);

    // R5 sweep of all hold codes, once mode (R6), W1C (R9), route (R8)
    for (int c = 0; c < 8; c++) begin
      lim = msOf(c);
      padIn = '0;
      writeReg(ADDR_MASK, 8'(1 << c));
      writeReg(ADDR_LEVEL, 8'h00);
      writeReg(ADDR_MODE, 8'h00);
      writeReg(ADDR_CTRL, 8'(8'h80 | (c << 4) | 5));
      activate(c, 1'b0, m);
      measure(c, (lim + 4) * DIV + 4, got);
      checkVal($sformatf("R5 fire edge code %0d", c), got, fireEdge(m, lim));
      readReg(ADDR_PEND, d); checkVal("R5 only own pin pending", d, 1 << c);
      checkVal("R8 irqOut with pending", int'(irqOut), 1);
      checkVal("R8 routeCode", int'(routeCode), 5);
      writeReg(ADDR_PEND, 8'h00);
      readReg(ADDR_PEND, d); checkVal("R9 zero write keeps pending", d, 1 << c);
      writeReg(ADDR_PEND, 8'(1 << c));
      readReg(ADDR_PEND, d); checkVal("R9 write-1 clears", d, 0);
      checkVal("R8 irqOut low after clear", int'(irqOut), 0);
      idle((lim + 2) * DIV);
      readReg(ADDR_PEND, d); checkVal("R6 once mode no refire", d, 0);
      teardown();
    end

    // R5 short hold: released one edge early, then restart
    lim = msOf(1);
    writeReg(ADDR_MASK, 8'h02);
    writeReg(ADDR_CTRL, 8'h80 | (1 << 4) | 1);
    activate(1, 1'b0, m);
    while (edgeCount < fireEdge(m, lim) - 1) @(negedge clk);
    padIn[1] = 1'b0;
    idle(4 * DIV);
    readReg(ADDR_PEND, d); checkVal("R5 short hold no request", d, 0);
    activate(1, 1'b0, m2);
    measure(1, (lim + 4) * DIV + 4, got);
    checkVal("R5 count restarts after release", got, fireEdge(m2, lim));
    teardown();

    // R3 active-low pin
    padIn = 8'hFF;
    writeReg(ADDR_LEVEL, 8'h10);
    writeReg(ADDR_MASK, 8'h10);
    writeReg(ADDR_CTRL, 8'h83);
    idle(8 * DIV);
    readReg(ADDR_PEND, d); checkVal("R3 high pad inactive when level=1", d, 0);
    activate(4, 1'b1, m);
    measure(4, (2 + 4) * DIV + 4, got);
    checkVal("R3 active-low fire edge", got, fireEdge(m, 2));
    teardown();

    // R2 mask: unmasked pin never fires
    writeReg(ADDR_MASK, 8'h01);
    writeReg(ADDR_CTRL, 8'h85);
    activate(3, 1'b0, m);
    idle(10 * DIV);
    readReg(ADDR_PEND, d); checkVal("R2 masked-off pin silent", d, 0);
    checkVal("R2 irqOut low", int'(irqOut), 0);
    teardown();

    // R4 global enable
    writeReg(ADDR_MASK, 8'h08);
    writeReg(ADDR_CTRL, 8'h05);
    activate(3, 1'b0, m);
    idle(10 * DIV);
    readReg(ADDR_PEND, d); checkVal("R4 disabled no request", d, 0);
    checkVal("R4 irqOut low when disabled", int'(irqOut), 0);
    writeReg(ADDR_CTRL, 8'h85);
    measure(3, 10 * DIV, got);
    checkVal("R4 enable starts counting", int'(got >= 0), 1);
    teardown();

    // R7 continuous mode
    lim = msOf(1);
    writeReg(ADDR_MASK, 8'h40);
    writeReg(ADDR_MODE, 8'h40);
    writeReg(ADDR_CTRL, 8'h80 | (1 << 4) | 2);
    activate(6, 1'b0, m);
    measure(6, (lim + 4) * DIV + 4, f1);
    checkVal("R7 first fire", f1, fireEdge(m, lim));
    writeReg(ADDR_PEND, 8'h40);
    measure(6, (lim + 4) * DIV, f2);
    checkVal("R7 second fire spacing", f2, f1 + lim * DIV);
    writeReg(ADDR_PEND, 8'h40);
    measure(6, (lim + 4) * DIV, got);
    checkVal("R7 third fire spacing", got, f2 + lim * DIV);
    padIn[6] = 1'b0;
    writeReg(ADDR_PEND, 8'h40);
    idle((lim + 3) * DIV);
    readReg(ADDR_PEND, d); checkVal("R7 stops when inactive", d, 0);
    teardown();

    // R8 routing code zero
    writeReg(ADDR_MASK, 8'h20);
    writeReg(ADDR_CTRL, 8'h80);
    activate(5, 1'b0, m);
    measure(5, 6 * DIV + 4, got);
    checkVal("R8 pending recorded with route 0", got, fireEdge(m, 2));
    checkVal("R8 irqOut low with route 0", int'(irqOut), 0);
    writeReg(ADDR_CTRL, 8'h8A);
    #1;
    checkVal("R8 irqOut after route set", int'(irqOut), 1);
    checkVal("R8 routeCode follows control", int'(routeCode), 10);
    teardown();

    // R6 once mode re-arms after inactive
    writeReg(ADDR_MASK, 8'h04);
    writeReg(ADDR_CTRL, 8'h81);
    activate(2, 1'b0, m);
    measure(2, 6 * DIV + 4, got);
    checkVal("R6 first activation", got, fireEdge(m, 2));
    writeReg(ADDR_PEND, 8'h04);
    @(negedge clk); padIn[2] = 1'b0;
    activate(2, 1'b0, m2);
    measure(2, 6 * DIV + 4, got);
    checkVal("R6 re-armed activation", got, fireEdge(m2, 2));
    teardown();

    finish();
  end
endmodule